// File: doc/BRIEF.md
# Dual-Threshold Transmit Refill Request Scheduler

This block decides when a transmit FIFO should ask the system bus for more data. It compares the FIFO's count of empty words against two programmable limits held in one 32-bit configuration word. Passing the urgent limit requests the bus on the next clock, whatever the bus is doing. Passing only the lenient limit requests the bus only after the bus has been quiet for a while. Small refills therefore happen on a lightly loaded bus, and the bus is claimed immediately only when the FIFO runs low.

The request is registered. Once raised, it stays up until a grant arrives, or until the count falls back to the limit that raised it. No request is made while no transmit descriptor is active. A chip reset clears the configuration word. A soft reset clears the request and the idle tracking but keeps the configuration.

Top module: `txrefill_sched`

## Requirements
- R1: After chip reset (`rst_n` low), `cfg_rdata` reads 0 and `bus_req` is 0.
- R2: A write with `cfg_we` high stores the urgent limit from `cfg_wdata[25:16]` and the lenient limit from `cfg_wdata[9:0]`. The two lowest bits of each limit are forced to 0. `cfg_rdata` returns the limits in the same positions, with every other bit reading 0.
- R3: With `bus_req` low, `desc_active` high, `soft_rst` low and `empty_cnt` strictly greater than the urgent limit, `bus_req` is 1 after the next clock edge, regardless of `bus_xfer`.
- R4: With the lenient limit crossed (count strictly greater), the bus idle, `desc_active` high and `soft_rst` low, `bus_req` rises at the next edge.
- R5: The bus counts as idle once `bus_xfer` has been low at four consecutive clock edges. Any edge with `bus_xfer` high restarts the count, and the count saturates instead of wrapping. When only the lenient limit is crossed, `bus_req` rises at the fifth edge of a quiet run.
- R6: While `desc_active` is low, `bus_req` is 0 after the next edge, and it cannot rise.
- R7: A raised `bus_req` falls at the edge where `grant` is sampled high. It can rise again at a later edge if a limit is still crossed.
- R8: A raised `bus_req` falls when `empty_cnt` is at or below the limit that raised it. An urgent-raised request is judged against the urgent limit, and a lenient-raised request against the lenient limit.
- R9: A limit of 0 is crossed by any nonzero empty count.
- R10: `soft_rst` high clears `bus_req` and the idle count at the next edge and leaves `cfg_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset, synchronous, keeps configuration |
| empty_cnt | input | 11 | Empty words in the transmit FIFO |
| bus_xfer | input | 1 | High in each cycle the bus carries a transfer |
| desc_active | input | 1 | A transmit descriptor is active |
| grant | input | 1 | Bus grant for the pending request |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| bus_req | output | 1 | Refill bus request |

## Verification
The assertions take the limits from the readback word. They assume `grant` arrives only while a request is pending and that `empty_cnt` stays inside its 11-bit range. They also assume any configuration write takes effect one edge after the condition the assertions sample. The random stimulus keeps grants and soft resets rare, so that requests both raise and drain. Writes are kept rare so that limits stay stable for long stretches, and quiet bus runs are made long enough for the idle condition to appear often.

// File: rtl/txrefill_sched.sv
module txrefill_sched #(
  parameter int THR_W    = 10,
  parameter int CNT_W    = 11,
  parameter int IDLE_CYC = 4,
  parameter int HARD_LSB = 16,
  parameter int SOFT_LSB = 0,
  parameter int ZERO_LSB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [CNT_W-1:0] empty_cnt,
  input  logic             bus_xfer,
  input  logic             desc_active,
  input  logic             grant,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             bus_req
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int KW = THR_W - ZERO_LSB;

  logic [KW-1:0] hard_q, soft_q;
  logic [IW-1:0] idle_q;
  logic          cause_hard_q;

  wire [THR_W-1:0] hard_thr = {hard_q, {ZERO_LSB{1'b0}}};
  wire [THR_W-1:0] soft_thr = {soft_q, {ZERO_LSB{1'b0}}};
  wire hard_hit = empty_cnt > CNT_W'(hard_thr);
  wire soft_hit = empty_cnt > CNT_W'(soft_thr);
  wire bus_idle = idle_q == IW'(IDLE_CYC);
  wire raise    = desc_active && (hard_hit || (soft_hit && bus_idle));
  wire keep     = desc_active && !grant && (cause_hard_q ? hard_hit : soft_hit);

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[HARD_LSB +: THR_W] = hard_thr;
    cfg_rdata[SOFT_LSB +: THR_W] = soft_thr;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hard_q <= '0;
      soft_q <= '0;
    end else if (cfg_we) begin
      hard_q <= cfg_wdata[HARD_LSB+ZERO_LSB +: KW];
      soft_q <= cfg_wdata[SOFT_LSB+ZERO_LSB +: KW];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        idle_q <= '0;
    else if (soft_rst || bus_xfer)     idle_q <= '0;
    else if (!bus_idle)                idle_q <= idle_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_req      <= 1'b0;
      cause_hard_q <= 1'b0;
    end else if (soft_rst) begin
      bus_req      <= 1'b0;
      cause_hard_q <= 1'b0;
    end else if (!bus_req) begin
      bus_req      <= raise;
      cause_hard_q <= hard_hit;
    end else begin
      bus_req      <= keep;
    end
endmodule

module txrefill_sched_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic [CNT_W-1:0] empty_cnt,
  input logic             desc_active,
  input logic             grant,
  input logic             cfg_we,
  input logic [31:0]      cfg_rdata,
  input logic             bus_req
);
  wire [CNT_W-1:0] hard_v = CNT_W'(cfg_rdata[25:16]);
  wire [CNT_W-1:0] soft_v = CNT_W'(cfg_rdata[9:0]);

  a_r2_fields_clean: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:26] == 0 && cfg_rdata[15:10] == 0 && cfg_rdata[17:16] == 0 && cfg_rdata[1:0] == 0);
  a_r3_hard_fires: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && desc_active && !soft_rst && empty_cnt > hard_v |=> bus_req);
  a_r6_no_desc: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_active |=> !bus_req);
  a_r7_grant_drops: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && grant |=> !bus_req);
  a_r8_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && empty_cnt <= hard_v && empty_cnt <= soft_v |=> !bus_req);
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !cfg_we |=> !bus_req && $stable(cfg_rdata));
endmodule

bind txrefill_sched txrefill_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .empty_cnt(empty_cnt),
  .desc_active(desc_active), .grant(grant), .cfg_we(cfg_we),
  .cfg_rdata(cfg_rdata), .bus_req(bus_req));

// File: tb/txrefill_sched_bench.sv
`timescale 1ns/1ps
module txrefill_sched_bench;
  logic clk = 0, rst_n = 0, soft_rst = 0, bus_xfer = 0, desc_active = 0, grant = 0, cfg_we = 0;
  logic [10:0] empty_cnt = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        bus_req;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txrefill_sched u_txrefill_sched (.*);

  // independent reference from the requirements
  logic [9:0] m_hard, m_soft;
  int         m_quiet;
  logic       m_req, m_urgent;

  function automatic logic [31:0] exp_rd(input logic [9:0] h, input logic [9:0] s);
    return {6'b0, h, 6'b0, s};
  endfunction
  function automatic bit crossed(input logic [10:0] c, input logic [9:0] t);
    return int'(c) > int'(t);
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_hard <= 0; m_soft <= 0; m_quiet <= 0; m_req <= 0; m_urgent <= 0;
    end else begin
      if (cfg_we) begin
        m_hard <= {cfg_wdata[25:18], 2'b00};
        m_soft <= {cfg_wdata[9:2], 2'b00};
      end
      m_quiet <= (soft_rst || bus_xfer) ? 0 : (m_quiet >= 4 ? 4 : m_quiet + 1);
      if (soft_rst) begin
        m_req <= 0; m_urgent <= 0;
      end else if (!m_req) begin
        m_req    <= desc_active && (crossed(empty_cnt, m_hard) || (crossed(empty_cnt, m_soft) && m_quiet >= 4));
        m_urgent <= crossed(empty_cnt, m_hard);
      end else begin
        m_req <= desc_active && !grant && (m_urgent ? crossed(empty_cnt, m_hard) : crossed(empty_cnt, m_soft));
      end
    end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_we = 1; cfg_wdata = d; step(); cfg_we = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(2);
    check(cfg_rdata == 0, "R1 rdata", cfg_rdata, 0);
    check(bus_req == 0, "R1 req", bus_req, 0);
    rst_n = 1; step();

    wr(32'hFFFF_FFFF); step();
    check(cfg_rdata == 32'h03FC_03FC, "R2 all ones", cfg_rdata, 32'h03FC_03FC);
    wr(32'h0107_0042);
    check(cfg_rdata == 32'h0104_0040, "R2 low bits", cfg_rdata, 32'h0104_0040);
    wr((32'd256 << 16) | 32'd64);

    desc_active = 0; empty_cnt = 500; step(3);
    check(bus_req == 0, "R6 no descriptor", bus_req, 0);

    desc_active = 1; bus_xfer = 1; empty_cnt = 300; step();
    check(bus_req == 1, "R3 hard on busy bus", bus_req, 1);
    grant = 1; step(); grant = 0;
    check(bus_req == 0, "R7 grant drop", bus_req, 0);
    step();
    check(bus_req == 1, "R7 rearm", bus_req, 1);
    empty_cnt = 256; step();
    check(bus_req == 0, "R8 hard limit", bus_req, 0);

    empty_cnt = 100; step(3);
    check(bus_req == 0, "R5 busy blocks soft", bus_req, 0);
    bus_xfer = 0; step(4);
    check(bus_req == 0, "R5 four quiet edges", bus_req, 0);
    step();
    check(bus_req == 1, "R4 soft on idle", bus_req, 1);
    bus_xfer = 1; step(2); bus_xfer = 0;
    check(bus_req == 1, "R7 holds without grant", bus_req, 1);
    empty_cnt = 64; step();
    check(bus_req == 0, "R8 soft limit", bus_req, 0);

    empty_cnt = 300; step();
    check(bus_req == 1, "R10 setup", bus_req, 1);
    soft_rst = 1; step(); soft_rst = 0;
    check(bus_req == 0, "R10 req cleared", bus_req, 0);
    check(cfg_rdata == exp_rd(10'd256, 10'd64), "R10 config kept", cfg_rdata, exp_rd(10'd256, 10'd64));
    step();
    desc_active = 0; step();
    check(bus_req == 0, "R6 drop", bus_req, 0);
    desc_active = 1;

    wr(32'h0); empty_cnt = 0; step(2);
    check(bus_req == 0, "R9 zero count", bus_req, 0);
    bus_xfer = 1; empty_cnt = 1; step();
    check(bus_req == 1, "R9 zero limit", bus_req, 1);
    empty_cnt = 0; step();
    check(bus_req == 0, "R9 drop", bus_req, 0);

    rst_n = 0; step(2); rst_n = 1;
    process::self().srandom(32'h5EED);
    for (int i = 0; i < 4000; i++) begin
      cfg_we      = ($urandom % 100) < 2;
      cfg_wdata   = $urandom;
      empty_cnt   = 11'($urandom % 1100);
      bus_xfer    = ($urandom % 100) < 25;
      desc_active = ($urandom % 100) < 92;
      grant       = bus_req && (($urandom % 100) < 10);
      soft_rst    = ($urandom % 1000) < 5;
      step();
      check(bus_req == m_req, "R3 R4 R8 model req", bus_req, m_req);
      check(cfg_rdata == exp_rd(m_hard, m_soft), "R2 model rdata", cfg_rdata, exp_rd(m_hard, m_soft));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule